// File: doc/BRIEF.md
# Reset Source Status Capture

This block records which event caused the most recent system reset and presents that cause in a read-only 16-bit status word. Five request lines feed it: power-on, the external reset pin, the watchdog's loss-of-reference signal, the watchdog's time-out signal and the software reset request. Each new request replaces whatever cause was stored before. When several requests begin in the same cycle, a fixed precedence picks one of them.

Power-on clears and initializes the block. While power-on is active the status shows the power-on cause. If the external pin is still held when power-on ends, the stored cause becomes the external cause. The external pin is asynchronous and passes through a two-flop synchronizer before it takes part in arbitration. The other reset events leave the stored cause in place, so software can read it after the reset has ended.

The block also drives a vector-select output for the boot logic. The output is high when the stored cause is one of the two watchdog causes, which selects the watchdog reset vector. Otherwise it is low, which selects the normal vector.

Top module: `rstCauseCapture`

## Requirements
- R1: Status layout: power-on cause at bit 2, external at bit 3, watchdog loss-of-reference at bit 4, watchdog time-out at bit 5, software at bit 6. All other bits read 0. `rdData` carries the status while `rdEn` is 1 and reads all zeros while `rdEn` is 0.
- R2: While `porReq` is 1, the status reads 0x0004 and `vecSelWdog` is 0. Power-on is the only event that reinitializes the status.
- R3: If the external pin is held high when `porReq` falls, the status changes from 0x0004 to 0x0008 at the third rising clock edge after the release.
- R4: A cause is latched at the clock edge where its request is first seen high. A request that stays high is not latched again.
- R5: The most recent cause replaces any earlier one. A cycle with no new request leaves the status unchanged.
- R6: Among requests that begin in the same cycle, the winner follows this precedence: external first, then loss-of-reference, then time-out, then software.
- R7: Exactly one cause bit is set at all times outside power-on.
- R8: `vecSelWdog` is 1 exactly when the status shows loss-of-reference (bit 4) or time-out (bit 5), and 0 otherwise.
- R9: A rise on the external pin first shows in the status at the third rising clock edge after it is sampled, because of the two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porReq | input | 1 | Power-on reset, active high, asynchronous; initializes the block |
| extPinReq | input | 1 | External reset pin, active high, asynchronous |
| lorReq | input | 1 | Watchdog loss-of-reference reset request, synchronous |
| torReq | input | 1 | Watchdog time-out reset request, synchronous |
| swReq | input | 1 | Software reset request, synchronous |
| rdEn | input | 1 | Status read enable |
| rdData | output | 16 | Status read data; zero when not reading |
| vecSelWdog | output | 1 | 1 selects the watchdog reset vector, 0 the normal vector |

## Verification
The hardest cases to reach are the ones where the external pin competes with another source. The first is the pin held across the end of power-on. The second is the pin rising in the same arbitration cycle as a watchdog request. The two synchronizer stages shift the pin's effect two cycles later than the synchronous requests. To line the events up, the stimulus raises the pin first, waits two edges, and only then raises the competing request. The pin-held case is reached by asserting the pin during power-on and releasing power-on while the pin stays high. The bench then checks that the status still reads the power-on value for two edges before it moves to the external value.

// File: rtl/rstCausePkg.sv
package rstCausePkg;
  localparam int CAUSE_N   = 5;
  localparam int STAT_W    = 16;
  localparam int CAUSE_LSB = 2;   // power-on cause sits at bit 2, others follow upward
  localparam int REQ_N     = CAUSE_N - 1;  // requests arbitrated after power-on

  typedef enum logic [2:0] {
    CAUSE_POR = 3'd0,
    CAUSE_EXT = 3'd1,
    CAUSE_LOR = 3'd2,
    CAUSE_TOR = 3'd3,
    CAUSE_SW  = 3'd4
  } causeE;

  typedef struct packed {
    logic  load;
    causeE sel;
  } strobeT;
endpackage

// File: rtl/rstCauseSync.sv
module rstCauseSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstAsync,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge rstAsync) begin
    if (rstAsync) chain <= '0;
    else          chain <= {chain[STAGES-2:0], dIn};
  end

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/rstCauseCtrl.sv
module rstCauseCtrl
  import rstCausePkg::*;
(
  input  logic   clk,
  input  logic   porReq,
  input  logic   extSync,
  input  logic   lorReq,
  input  logic   torReq,
  input  logic   swReq,
  output strobeT strobe
);
  // index 0 has the highest precedence
  logic [REQ_N-1:0] reqNow;
  logic [REQ_N-1:0] reqPrev;
  logic [REQ_N-1:0] reqRise;

  assign reqNow  = {swReq, torReq, lorReq, extSync};
  assign reqRise = reqNow & ~reqPrev;

  always_ff @(posedge clk or posedge porReq) begin
    if (porReq) reqPrev <= '0;
    else        reqPrev <= reqNow;
  end

  always_comb begin
    strobe.load = |reqRise;
    strobe.sel  = CAUSE_SW;
    for (int i = REQ_N - 1; i >= 0; i--) begin
      if (reqRise[i]) strobe.sel = causeE'(3'(i + 1));
    end
  end
endmodule

// File: rtl/rstCauseDatapath.sv
module rstCauseDatapath
  import rstCausePkg::*;
(
  input  logic              clk,
  input  logic              porReq,
  input  strobeT            strobe,
  input  logic              rdEn,
  output logic [STAT_W-1:0] rdData,
  output logic              vecSelWdog
);
  logic [CAUSE_N-1:0] causeOneHot;
  logic [STAT_W-1:0]  statWord;

  always_ff @(posedge clk or posedge porReq) begin
    if (porReq)           causeOneHot <= CAUSE_N'(1) << CAUSE_POR;
    else if (strobe.load) causeOneHot <= CAUSE_N'(1) << strobe.sel;
  end

  always_comb begin
    statWord = '0;
    statWord[CAUSE_LSB +: CAUSE_N] = causeOneHot;
  end

  assign rdData     = rdEn ? statWord : '0;
  assign vecSelWdog = causeOneHot[CAUSE_LOR] | causeOneHot[CAUSE_TOR];
endmodule

// File: rtl/rstCauseCapture.sv
module rstCauseCapture
  import rstCausePkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              porReq,
  input  logic              extPinReq,
  input  logic              lorReq,
  input  logic              torReq,
  input  logic              swReq,
  input  logic              rdEn,
  output logic [STAT_W-1:0] rdData,
  output logic              vecSelWdog
);
  logic   extSync;
  strobeT strobe;

  rstCauseSync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstAsync(porReq), .dIn(extPinReq), .dOut(extSync)
  );

  rstCauseCtrl ctrl_i (
    .clk(clk), .porReq(porReq), .extSync(extSync),
    .lorReq(lorReq), .torReq(torReq), .swReq(swReq), .strobe(strobe)
  );

  rstCauseDatapath dp_i (
    .clk(clk), .porReq(porReq), .strobe(strobe),
    .rdEn(rdEn), .rdData(rdData), .vecSelWdog(vecSelWdog)
  );
endmodule

// File: rtl/rstCauseCheck.sv
module rstCauseCheck (
  input logic        clk,
  input logic        porReq,
  input logic        rdEn,
  input logic [15:0] rdData,
  input logic        vecSelWdog
);
  // R1: reserved bits never set
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (porReq)
    (rdData & 16'hFF83) == 16'h0000);

  // R1: no data without a read
  assert_idle_read_R1: assert property (@(posedge clk) disable iff (porReq)
    !rdEn |-> rdData == 16'h0000);

  // R7: exactly one cause bit
  assert_one_cause_R7: assert property (@(posedge clk) disable iff (porReq)
    rdEn |-> $countones(rdData) == 1);

  // R8: vector select agrees with the watchdog cause bits
  assert_vec_select_R8: assert property (@(posedge clk) disable iff (porReq)
    rdEn |-> vecSelWdog == (rdData[4] | rdData[5]));
endmodule

bind rstCauseCapture rstCauseCheck chk_i (
  .clk(clk), .porReq(porReq), .rdEn(rdEn), .rdData(rdData), .vecSelWdog(vecSelWdog)
);

// File: tb/rstCauseCapture_tb_top.sv
module rstCauseCapture_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic porReq = 1'b1, extPinReq = 1'b0, lorReq = 1'b0, torReq = 1'b0, swReq = 1'b0;
  logic rdEn = 1'b0;
  logic [15:0] rdData;
  logic vecSelWdog;
  int nChecks = 0;
  int nErrs = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rstCauseCapture dut_i (
    .clk(clk), .porReq(porReq), .extPinReq(extPinReq), .lorReq(lorReq),
    .torReq(torReq), .swReq(swReq), .rdEn(rdEn), .rdData(rdData), .vecSelWdog(vecSelWdog)
  );

  // row: {swReq, torReq, lorReq, expected status}
  localparam logic [18:0] VEC [8] = '{
    {3'b100, 16'h0040},
    {3'b010, 16'h0020},
    {3'b001, 16'h0010},
    {3'b110, 16'h0020},
    {3'b111, 16'h0010},
    {3'b101, 16'h0010},
    {3'b000, 16'h0010},
    {3'b100, 16'h0040}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chkRead(input string req, input logic [15:0] exp);
    chk(req, rdData, exp);
    chk({req, "_R8"}, {15'd0, vecSelWdog}, {15'd0, (exp[4] | exp[5])});
  endtask

  task automatic finishRun;
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nErrs++;
    $display("FAIL watchdog act=timeout exp=done");
    finishRun();
  end

  initial begin
    rdEn = 1'b1;
    tick(2);
    chkRead("R2", 16'h0004);
    extPinReq = 1'b1;
    tick(2);
    chkRead("R2", 16'h0004);
    porReq = 1'b0;               // pin still held
    tick(2);
    chkRead("R3", 16'h0004);
    tick(1);
    chkRead("R3", 16'h0008);
    swReq = 1'b1;
    tick(1);
    chkRead("R5", 16'h0040);
    swReq = 1'b0;
    rdEn = 1'b0;
    tick(1);
    chk("R1", rdData, 16'h0000);
    rdEn = 1'b1;
    extPinReq = 1'b0;
    tick(3);

    for (int i = 0; i < 8; i++) begin
      {swReq, torReq, lorReq} = VEC[i][18:16];
      tick(1);
      chkRead("R6", VEC[i][15:0]);
      {swReq, torReq, lorReq} = 3'b000;
      tick(1);
      chkRead("R5", VEC[i][15:0]);
    end

    extPinReq = 1'b1;
    tick(2);
    chkRead("R9", 16'h0040);
    tick(1);
    chkRead("R9", 16'h0008);
    extPinReq = 1'b0;
    tick(3);

    extPinReq = 1'b1;            // lines up with lorReq in arbitration
    tick(2);
    lorReq = 1'b1;
    tick(1);
    chkRead("R6", 16'h0008);
    lorReq = 1'b0;
    extPinReq = 1'b0;
    tick(3);

    swReq = 1'b1;
    tick(1);
    chkRead("R4", 16'h0040);
    lorReq = 1'b1;
    tick(1);
    chkRead("R5", 16'h0010);
    lorReq = 1'b0;
    tick(3);
    chkRead("R4", 16'h0010);
    swReq = 1'b0;
    tick(1);

    porReq = 1'b1;
    tick(1);
    chkRead("R2", 16'h0004);
    porReq = 1'b0;
    tick(3);
    chkRead("R2", 16'h0004);

    finishRun();
  end
endmodule